// File: doc/BRIEF.md
# Skewed Multi-Bank Coefficient Scratchpad

This block is the on-chip working store for an iterative number theoretic transform. It holds `LANES * ROWS` coefficients of `WIDTH` bits spread over `LANES` single-port-per-direction banks. Every cycle it can read one group of `LANES` coefficients and write another group of `LANES` coefficients, and no two lanes of a group ever land in the same bank. Results written by one pass stay in the banks, so a later pass reads them directly without a trip to external memory.

Coefficient `i` lives in bank `(i + i/LANES) mod LANES` at row `i/LANES`. This diagonal skew serves two group shapes. A sequential group holds `LANES` consecutive coefficients. A strided group holds `LANES/2` butterfly pairs whose members are half the vector apart. The shape is chosen by the iteration-type select. Linear burst beats to and from external memory use the sequential shape. A rotation-and-interleave network puts the data back in order, so output lane `k` always carries the `k`-th element of the group. Bank reads are read-first.

Top module: `scratchpad_skew`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, `rd_valid` and `st_valid` are 0 and `rd_data` is all zeros.
- R2: A load beat `b` (`ld_en`) writes lane `k` of `ld_data` to coefficient `b*LANES+k`. A store beat `b` (`st_en`) returns coefficient `b*LANES+k` on lane `k` of `rd_data`, with `st_valid` high on the second rising edge after the request.
- R3: A read with `it_mode`=0 (sequential) of group `g` returns coefficient `g*LANES+k` on lane `k`, with `rd_valid` high on the second rising edge after the request.
- R4: A read with `it_mode`=1 (strided) of group `g` returns coefficient `g*LANES/2 + k/2` on an even lane `k`, and that index plus `LANES*ROWS/2` on an odd lane `k`.
- R5: A write with `it_mode`=0 of group `g` stores lane `k` of `wr_data` to coefficient `g*LANES+k`.
- R6: A write with `it_mode`=1 of group `g` stores each lane at the coefficient index that R4 gives for that lane.
- R7: A read and a write issued in the same cycle to the same group return the data as it was before that write.
- R8: Reads issued on consecutive cycles produce results on consecutive cycles, in issue order, with no gaps.
- R9: When `ld_en` and `wr_en` are both high, the compute write is dropped. When `st_en` and `rd_en` are both high, the compute read is dropped: only `st_valid` rises and `rd_data` carries the store beat.
- R10: Every read access and every write access touches each bank exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| it_mode | input | 1 | Group shape for compute access: 0 sequential, 1 strided |
| ld_en | input | 1 | Burst load beat strobe |
| ld_beat | input | $clog2(ROWS) | Burst load beat number |
| ld_data | input | LANES*WIDTH | Burst load data, lane k at bits [k*WIDTH +: WIDTH] |
| st_en | input | 1 | Burst store beat request |
| st_beat | input | $clog2(ROWS) | Burst store beat number |
| wr_en | input | 1 | Compute write strobe |
| wr_grp | input | $clog2(ROWS) | Compute write group |
| wr_data | input | LANES*WIDTH | Compute write data, lane-ordered |
| rd_en | input | 1 | Compute read request |
| rd_grp | input | $clog2(ROWS) | Compute read group |
| rd_valid | output | 1 | rd_data holds a compute read result |
| st_valid | output | 1 | rd_data holds a burst store beat |
| rd_data | output | LANES*WIDTH | Registered lane-ordered read data |

## Verification
The assertions assume that `ROWS/2` is congruent to `LANES/2` modulo `LANES`. They also assume that the enables are driven low while reset is high, so that the two-cycle latency checks start from a clean pipeline. The stimulus uses the default configuration, which meets the congruence, and it holds every strobe at 0 during reset. The bench sweeps every group in both shapes, with distinct value patterns for the load, the strided write and the sequential write. It then targets same-group read/write collisions and simultaneous burst and compute requests.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic {
    MODE_SEQ    = 1'b0,
    MODE_STRIDE = 1'b1
  } ss_mode_e;
endpackage

// File: rtl/ss_addr_gen.sv
// Per-bank row addresses and lane routing for one group access.
// BY_BANK=1: sel[b] = lane feeding bank b (write side).
// BY_BANK=0: sel[k] = bank feeding lane k (read side).
module ss_addr_gen #(
  parameter int LANES   = 16,
  parameter int ROWS    = 16,
  parameter bit BY_BANK = 1'b1,
  localparam int LW = $clog2(LANES),
  localparam int RW = $clog2(ROWS)
) (
  input  ss_pkg::ss_mode_e         mode,
  input  logic [RW-1:0]            grp,
  output logic [LANES-1:0][RW-1:0] row,
  output logic [LANES-1:0][LW-1:0] sel
);
  import ss_pkg::*;
  localparam int HALF_L = LANES / 2;
  localparam int HALF_R = ROWS / 2;

  int g;
  int rot;

  always_comb begin
    g = int'(grp);
    if (mode == MODE_STRIDE) rot = ((g % 2) * HALF_L + g / 2) % LANES;
    else                     rot = g % LANES;
  end

  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      int d;
      d = (b - rot + LANES) % LANES;
      if (mode == MODE_STRIDE) row[b] = (d < HALF_L) ? RW'(g / 2) : RW'(g / 2 + HALF_R);
      else                     row[b] = RW'(g);
    end
  end

  generate
    if (BY_BANK) begin : g_by_bank
      always_comb begin
        for (int b = 0; b < LANES; b++) begin
          int d;
          d = (b - rot + LANES) % LANES;
          if (mode == MODE_STRIDE) sel[b] = (d < HALF_L) ? LW'(2 * d) : LW'(2 * (d - HALF_L) + 1);
          else                     sel[b] = LW'(d);
        end
      end
    end else begin : g_by_lane
      always_comb begin
        for (int k = 0; k < LANES; k++) begin
          if (mode == MODE_STRIDE) sel[k] = LW'((rot + k / 2 + (k % 2) * HALF_L) % LANES);
          else                     sel[k] = LW'((rot + k) % LANES);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ss_bank.sv
// One coefficient bank: one write and one read per cycle, read-first, registered output.
module ss_bank #(
  parameter int WIDTH = 64,
  parameter int ROWS  = 16,
  localparam int RW = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [RW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [RW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ss_lane_xbar.sv
// Full LANES-to-LANES selector: output o takes input sel[o].
module ss_lane_xbar #(
  parameter int LANES = 16,
  parameter int WIDTH = 64,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LANES-1:0][WIDTH-1:0] din,
  input  logic [LANES-1:0][LW-1:0]    sel,
  output logic [LANES-1:0][WIDTH-1:0] dout
);
  always_comb begin
    for (int o = 0; o < LANES; o++) dout[o] = din[sel[o]];
  end
endmodule

// File: rtl/scratchpad_skew.sv
// Skewed banked scratchpad. Coefficient i -> bank (i + i/LANES) % LANES, row i/LANES.
// Conflict-free strided groups need (ROWS/2) % LANES == LANES/2.
module scratchpad_skew #(
  parameter int LANES = 16,
  parameter int ROWS  = 16,
  parameter int WIDTH = 64,
  localparam int LW = $clog2(LANES),
  localparam int GW = $clog2(ROWS),
  localparam int DW = LANES * WIDTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          it_mode,
  input  logic          ld_en,
  input  logic [GW-1:0] ld_beat,
  input  logic [DW-1:0] ld_data,
  input  logic          st_en,
  input  logic [GW-1:0] st_beat,
  input  logic          wr_en,
  input  logic [GW-1:0] wr_grp,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [GW-1:0] rd_grp,
  output logic          rd_valid,
  output logic          st_valid,
  output logic [DW-1:0] rd_data
);
  import ss_pkg::*;

  // Port arbitration: burst traffic wins over compute traffic on each side.
  ss_mode_e w_mode, r_mode;
  logic [GW-1:0] w_grp, r_grp;
  logic w_go, r_go;
  logic [LANES-1:0][WIDTH-1:0] w_lanes;

  always_comb begin
    w_go    = ld_en | wr_en;
    w_mode  = ld_en ? MODE_SEQ : ss_mode_e'(it_mode);
    w_grp   = ld_en ? ld_beat : wr_grp;
    w_lanes = ld_en ? ld_data : wr_data;
    r_go    = st_en | rd_en;
    r_mode  = st_en ? MODE_SEQ : ss_mode_e'(it_mode);
    r_grp   = st_en ? st_beat : rd_grp;
  end

  logic [LANES-1:0][GW-1:0] w_row, r_row;
  logic [LANES-1:0][LW-1:0] wr_sel, rd_sel;

  ss_addr_gen #(.LANES(LANES), .ROWS(ROWS), .BY_BANK(1'b1)) u_wr_map (
    .mode(w_mode), .grp(w_grp), .row(w_row), .sel(wr_sel)
  );
  ss_addr_gen #(.LANES(LANES), .ROWS(ROWS), .BY_BANK(1'b0)) u_rd_map (
    .mode(r_mode), .grp(r_grp), .row(r_row), .sel(rd_sel)
  );

  // Write side: lane order -> bank order.
  logic [LANES-1:0][WIDTH-1:0] w_banks;
  ss_lane_xbar #(.LANES(LANES), .WIDTH(WIDTH)) u_wr_xbar (
    .din(w_lanes), .sel(wr_sel), .dout(w_banks)
  );

  logic [LANES-1:0][WIDTH-1:0] bank_q;
  generate
    for (genvar b = 0; b < LANES; b++) begin : g_bank
      ss_bank #(.WIDTH(WIDTH), .ROWS(ROWS)) u_bank (
        .clk(clk), .we(w_go), .waddr(w_row[b]), .wdata(w_banks[b]),
        .re(r_go), .raddr(r_row[b]), .rdata(bank_q[b])
      );
    end
  endgenerate

  // Stage 1 carries the routing alongside the bank read.
  logic s1_go, s1_st;
  logic [LANES-1:0][LW-1:0] s1_sel;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_go  <= 1'b0;
      s1_st  <= 1'b0;
      s1_sel <= '0;
    end else begin
      s1_go  <= r_go;
      s1_st  <= st_en;
      s1_sel <= rd_sel;
    end
  end

  // Read side: bank order -> lane order, then output register.
  logic [LANES-1:0][WIDTH-1:0] r_lanes;
  ss_lane_xbar #(.LANES(LANES), .WIDTH(WIDTH)) u_rd_xbar (
    .din(bank_q), .sel(s1_sel), .dout(r_lanes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      st_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= s1_go & ~s1_st;
      st_valid <= s1_go & s1_st;
      if (s1_go) rd_data <= r_lanes;
    end
  end
endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
  parameter int LANES = 16,
  localparam int LW = $clog2(LANES)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     rd_en,
  input logic                     st_en,
  input logic                     wr_en,
  input logic                     ld_en,
  input logic                     rd_valid,
  input logic                     st_valid,
  input logic [LANES-1:0][LW-1:0] rd_sel,
  input logic [LANES-1:0][LW-1:0] wr_sel
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  logic [LANES-1:0] rd_cov, wr_cov;
  always_comb begin
    rd_cov = '0;
    wr_cov = '0;
    for (int k = 0; k < LANES; k++) begin
      rd_cov[rd_sel[k]] = 1'b1;
      wr_cov[wr_sel[k]] = 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!rd_valid && !st_valid));

  assert_st_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (st_valid == $past(st_en, 2)));

  assert_rd_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (rd_valid == $past(rd_en && !st_en, 2)));

  assert_rd_banks_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en || st_en) |-> (&rd_cov));

  assert_wr_banks_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en || ld_en) |-> (&wr_cov));
endmodule

bind scratchpad_skew ss_checker #(.LANES(LANES)) u_ss_checker (
  .clk(clk), .rst(rst), .rd_en(rd_en), .st_en(st_en), .wr_en(wr_en), .ld_en(ld_en),
  .rd_valid(rd_valid), .st_valid(st_valid), .rd_sel(rd_sel), .wr_sel(wr_sel)
);

// File: tb/tb_scratchpad_skew.sv
`timescale 1ns/1ps
module tb_scratchpad_skew;
  localparam int P  = 16;
  localparam int RS = 16;
  localparam int W  = 64;
  localparam int N  = P * RS;
  localparam int GW = $clog2(RS);
  localparam int DW = P * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic it_mode = 1'b0;
  logic ld_en = 1'b0, st_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [GW-1:0] ld_beat = '0, st_beat = '0, wr_grp = '0, rd_grp = '0;
  logic [DW-1:0] ld_data = '0, wr_data = '0;
  logic rd_valid, st_valid;
  logic [DW-1:0] rd_data;

  always #2 clk = ~clk;

  scratchpad_skew #(.LANES(P), .ROWS(RS), .WIDTH(W)) dut (
    .clk(clk), .rst(rst), .it_mode(it_mode),
    .ld_en(ld_en), .ld_beat(ld_beat), .ld_data(ld_data),
    .st_en(st_en), .st_beat(st_beat),
    .wr_en(wr_en), .wr_grp(wr_grp), .wr_data(wr_data),
    .rd_en(rd_en), .rd_grp(rd_grp),
    .rd_valid(rd_valid), .st_valid(st_valid), .rd_data(rd_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cur_tag = 3;
  bit done = 1'b0;

  function automatic string tname(int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  // Coefficient index carried by lane k of group g (R3/R4 maps).
  function automatic int idx(logic mode, int g, int k);
    if (mode) return g * (P / 2) + k / 2 + (k % 2) * (N / 2);
    return g * P + k;
  endfunction

  function automatic logic [W-1:0] pat(int i, logic [31:0] seed);
    return {seed, 16'h5AC3, 16'(i)};
  endfunction

  function automatic logic [DW-1:0] mkvec(logic mode, int g, logic [31:0] seed);
    logic [DW-1:0] v;
    for (int k = 0; k < P; k++) v[k*W +: W] = pat(idx(mode, g, k), seed);
    return v;
  endfunction

  task automatic check(bit ok, int tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tname(tag), act, exp);
    end
  endtask

  // Reference model: expectation snapshot at issue (read-first), then writes.
  logic [W-1:0] mem_ref [N];
  logic p1_rd, p1_st, p2_rd, p2_st;
  int p1_tag, p2_tag;
  logic [DW-1:0] p1_exp, p2_exp, exp_now;

  always @(posedge clk) begin
    if (rst) begin
      p1_rd <= 1'b0; p1_st <= 1'b0; p2_rd <= 1'b0; p2_st <= 1'b0;
      p1_tag <= 0; p2_tag <= 0; p1_exp <= '0; p2_exp <= '0;
    end else begin
      exp_now = '0;
      for (int k = 0; k < P; k++) begin
        if (st_en)      exp_now[k*W +: W] = mem_ref[idx(1'b0, int'(st_beat), k)];
        else if (rd_en) exp_now[k*W +: W] = mem_ref[idx(it_mode, int'(rd_grp), k)];
      end
      p1_rd <= rd_en && !st_en; p1_st <= st_en; p1_tag <= cur_tag; p1_exp <= exp_now;
      p2_rd <= p1_rd; p2_st <= p1_st; p2_tag <= p1_tag; p2_exp <= p1_exp;
      for (int k = 0; k < P; k++) begin
        if (ld_en)      mem_ref[idx(1'b0, int'(ld_beat), k)] = ld_data[k*W +: W];
        else if (wr_en) mem_ref[idx(it_mode, int'(wr_grp), k)] = wr_data[k*W +: W];
      end
    end
  end

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(rd_valid == p2_rd && st_valid == p2_st, p2_tag,
            DW'({rd_valid, st_valid}), DW'({p2_rd, p2_st}));
      if (p2_rd || p2_st) check(rd_data == p2_exp, p2_tag, rd_data, p2_exp);
    end
  end

  task automatic idle();
    ld_en = 1'b0; st_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic drain();
    idle();
    repeat (3) @(negedge clk);
  endtask

  task automatic burst_load_all(logic [31:0] seed);
    for (int b = 0; b < RS; b++) begin
      idle(); ld_en = 1'b1; ld_beat = GW'(b); ld_data = mkvec(1'b0, b, seed);
      @(negedge clk);
    end
    drain();
  endtask

  task automatic burst_store_all(int tag);
    cur_tag = tag;
    for (int b = 0; b < RS; b++) begin
      idle(); st_en = 1'b1; st_beat = GW'(b);
      @(negedge clk);
    end
    drain();
  endtask

  task automatic read_all(logic mode, int tag);
    cur_tag = tag; it_mode = mode;
    for (int g = 0; g < RS; g++) begin
      idle(); rd_en = 1'b1; rd_grp = GW'(g);
      @(negedge clk);
    end
    drain();
  endtask

  task automatic write_all(logic mode, logic [31:0] seed);
    it_mode = mode;
    for (int g = 0; g < RS; g++) begin
      idle(); wr_en = 1'b1; wr_grp = GW'(g); wr_data = mkvec(mode, g, seed);
      @(negedge clk);
    end
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet and zero in reset
    check(!rd_valid && !st_valid && rd_data == '0, 1, rd_data, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!rd_valid && !st_valid && rd_data == '0, 1, rd_data, '0);

    burst_load_all(32'h1111_0000);       // R2 load
    burst_store_all(2);                  // R2 store order
    read_all(1'b0, 8);                   // R3 sequential, R8 back-to-back
    read_all(1'b0, 3);
    read_all(1'b1, 4);                   // R4 strided
    write_all(1'b1, 32'h2222_0000);      // R6 strided write
    burst_store_all(6);
    read_all(1'b1, 6);
    write_all(1'b0, 32'h3333_0000);      // R5 sequential write
    read_all(1'b0, 5);
    read_all(1'b1, 10);                  // R10 strided over new data

    // R7: same-group read and write in one cycle gives old data
    for (int m = 0; m < 2; m++) begin
      cur_tag = 7; it_mode = m[0];
      idle(); rd_en = 1'b1; rd_grp = GW'(2 + m); wr_en = 1'b1; wr_grp = GW'(2 + m);
      wr_data = mkvec(m[0], 2 + m, 32'h7777_0000);
      @(negedge clk);
      idle(); rd_en = 1'b1;
      @(negedge clk);
      drain();
    end

    // R9: burst load beats the compute write; burst store beats the compute read
    cur_tag = 9; it_mode = 1'b0;
    idle(); ld_en = 1'b1; ld_beat = GW'(3); ld_data = mkvec(1'b0, 3, 32'h9999_0000);
    wr_en = 1'b1; wr_grp = GW'(5); wr_data = mkvec(1'b0, 5, 32'hBAD0_0000);
    @(negedge clk);
    idle(); st_en = 1'b1; st_beat = GW'(5);
    @(negedge clk);
    idle(); st_en = 1'b1; st_beat = GW'(3); rd_en = 1'b1; rd_grp = GW'(7);
    @(negedge clk);
    drain();

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL R8 actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule